// File: doc/BRIEF.md
# Audio Processor Control Receiver

This block is a write-only two-wire serial slave that keeps the control settings of a stereo audio processor. It samples the serial clock and data lines with a fast system clock, recognises START and STOP conditions and accepts an address byte. If the address matches, it acknowledges the byte. The following byte selects a target function and the bytes after that carry data. Five control registers are held: left volume, right volume, bass, treble and a switch-function register. Their contents drive parallel outputs that go to the analog path.

A host writes one or more settings per transfer. The function pointer advances by itself after every data byte, so one transfer can load all five registers. After reset the mute bit is set. It changes only when the host writes the switch-function register.

The receiver is a state machine with eight states. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. ST_ADDR_ACK drives the acknowledge. ST_SUB shifts in the function byte. ST_SUB_ACK acknowledges it. ST_DATA shifts in a data byte. ST_DATA_ACK acknowledges it and loops back to ST_DATA. ST_SKIP holds off a transfer that is not for this slave.

The transitions are as follows. A START in any state goes to ST_ADDR, and a STOP in any state goes to ST_IDLE. On a falling serial clock with eight bits received, ST_ADDR goes to ST_ADDR_ACK when the address matches and to ST_SKIP when it does not. ST_SUB goes to ST_SUB_ACK and ST_DATA goes to ST_DATA_ACK in the same way. On the falling clock that ends the ninth bit, ST_ADDR_ACK goes to ST_SUB, and ST_SUB_ACK and ST_DATA_ACK go to ST_DATA.

Top module: `audio_ctl_rx`

## Requirements
- R1: After reset, mute is 1 and sda_oe is 0. All other register outputs (both volumes, bass, treble, effect_en, stereo_lin, mode_sel, input_sel) are 0.
- R2: A START condition (SDA falling while SCL is high) restarts reception at any point with a fresh address byte. A partly received byte is discarded and writes nothing.
- R3: A STOP condition (SDA rising while SCL is high) returns the receiver to idle. Clock pulses after a STOP and before the next START are not acknowledged and change no register.
- R4: An address byte equal to {DEV_ADDR, 1'b0} (DEV_ADDR defaults to 7'h41, so the byte is 8'h82) is acknowledged. Any other address byte is not acknowledged, including one with bit 0 set to 1. After a mismatch, every further byte is ignored and not acknowledged until the next START.
- R5: An acknowledge holds sda_oe at 1. It starts at the SCL fall after the eighth bit of an accepted byte and ends at the SCL fall after the ninth clock. sda_oe changes only while SCL is low.
- R6: The byte after the address is the subaddress and is always acknowledged. A data byte at subaddress 8'h00 loads vol_left from bits 5..0. At 8'h01 it loads vol_right from bits 5..0. At 8'h02 it loads bass_code from bits 3..0, and at 8'h03 it loads treble_code from bits 3..0. The remaining upper bits are ignored.
- R7: A data byte at subaddress 8'h08 loads the switch functions: mute from bit 5, effect_en from bit 4, stereo_lin from bit 3, mode_sel from bits 2..1 and input_sel from bit 0.
- R8: After each data byte the subaddress steps 00, 01, 02, 03, 08. It then stays at 08, so further bytes rewrite the switch register.
- R9: At any other subaddress, data bytes are acknowledged, no register changes, and the subaddress does not move.
- R10: The mute output changes only through a data byte written at subaddress 8'h08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| vol_left | output | 6 | Left volume code |
| vol_right | output | 6 | Right volume code |
| bass_code | output | 4 | Bass setting code |
| treble_code | output | 4 | Treble setting code |
| mute | output | 1 | Mute active |
| effect_en | output | 1 | Effect switch |
| stereo_lin | output | 1 | Stereo/linear switch |
| mode_sel | output | 2 | Sound mode select |
| input_sel | output | 1 | Source input select |

## Verification
Two functions fall on the same clock edge: a data byte being committed to a register and the subaddress stepping to its successor. The bench provokes this with runs of back-to-back data bytes behind one subaddress. The runs cross the 03-to-08 jump and keep writing at 08, where the pointer must hold. A scoreboard model applies the write first and then the step for every byte. After each acknowledge it compares all register outputs, so a step taken before the write, or a write that goes missing, shows up as a mismatch in a named register.

// File: rtl/actl_pkg.sv
package actl_pkg;

    localparam int BYTE_W = 8;
    localparam int VOL_W  = 6;
    localparam int TONE_W = 4;
    localparam int SW_W   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_t;

    localparam logic [BYTE_W-1:0] SA_VOL_L  = 8'h00;
    localparam logic [BYTE_W-1:0] SA_VOL_R  = 8'h01;
    localparam logic [BYTE_W-1:0] SA_BASS   = 8'h02;
    localparam logic [BYTE_W-1:0] SA_TREBLE = 8'h03;
    localparam logic [BYTE_W-1:0] SA_SWITCH = 8'h08;

    typedef struct packed {
        logic       mute;
        logic       effect;
        logic       stereo_lin;
        logic [1:0] mode;
        logic       input_sel;
    } sw_fields_t;

    function automatic logic [BYTE_W-1:0] sub_successor(input logic [BYTE_W-1:0] s);
        case (s)
            SA_VOL_L:             return SA_VOL_R;
            SA_VOL_R:             return SA_BASS;
            SA_BASS:              return SA_TREBLE;
            SA_TREBLE, SA_SWITCH: return SA_SWITCH;
            default:              return s;
        endcase
    endfunction

endpackage

// File: rtl/actl_line_sync.sv
module actl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/actl_rx_fsm.sv
module actl_rx_fsm
    import actl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              sub_ld,
    output logic              wr,
    output logic [BYTE_W-1:0] byte_q
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] MATCH = {DEV_ADDR, 1'b0};

    rx_state_t         state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              receiving;
    logic              full;

    assign receiving = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign full      = (bit_cnt == FULL);

    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_ADDR:     if (full) state_n = (shreg == MATCH) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: state_n = ST_SUB;
                ST_SUB:      if (full) state_n = ST_SUB_ACK;
                ST_SUB_ACK:  state_n = ST_DATA;
                ST_DATA:     if (full) state_n = ST_DATA_ACK;
                ST_DATA_ACK: state_n = ST_DATA;
                ST_SKIP:     state_n = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // bit collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start_det || (state_n != state)) begin
            bit_cnt <= '0;
        end else if (scl_rise && receiving && !full) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
            sub_ld <= 1'b0;
            wr     <= 1'b0;
        end else begin
            sda_oe <= (state_n == ST_ADDR_ACK) || (state_n == ST_SUB_ACK) ||
                      (state_n == ST_DATA_ACK);
            sub_ld <= (state == ST_SUB)  && (state_n == ST_SUB_ACK);
            wr     <= (state == ST_DATA) && (state_n == ST_DATA_ACK);
        end
    end

    assign byte_q = shreg;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl); // R5
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR) && (bit_cnt == '0)); // R2
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE)); // R3
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_oe && !wr); // R4
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !wr); // R6

endmodule

// File: rtl/actl_regbank.sv
module actl_regbank
    import actl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_ld,
    input  logic              wr,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [VOL_W-1:0]  vol_l,
    output logic [VOL_W-1:0]  vol_r,
    output logic [TONE_W-1:0] bass,
    output logic [TONE_W-1:0] treble,
    output sw_fields_t        sw
);

    logic [BYTE_W-1:0] sub_q;
    logic [BYTE_W-1:0] unused_hi;

    assign unused_hi = byte_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= SA_VOL_L;
            vol_l  <= '0;
            vol_r  <= '0;
            bass   <= '0;
            treble <= '0;
            sw     <= '{mute: 1'b1, effect: 1'b0, stereo_lin: 1'b0,
                        mode: 2'b00, input_sel: 1'b0};
        end else if (sub_ld) begin
            sub_q <= byte_in;
        end else if (wr) begin
            sub_q <= sub_successor(sub_q);
            case (sub_q)
                SA_VOL_L:  vol_l  <= byte_in[VOL_W-1:0];
                SA_VOL_R:  vol_r  <= byte_in[VOL_W-1:0];
                SA_BASS:   bass   <= byte_in[TONE_W-1:0];
                SA_TREBLE: treble <= byte_in[TONE_W-1:0];
                SA_SWITCH: sw     <= sw_fields_t'(byte_in[SW_W-1:0]);
                default:   ;
            endcase
        end
    end

    AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (sub_q == SA_SWITCH)) |=> $stable(sw.mute)); // R10
    AST_STEP_TO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sub_q == SA_TREBLE)) |=> (sub_q == SA_SWITCH)); // R8
    AST_SWITCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sub_q == SA_SWITCH)) |=> (sub_q == SA_SWITCH)); // R8
    AST_QUIET_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable({vol_l, vol_r, bass, treble, sw})); // R3
    AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sub_q > SA_TREBLE) && (sub_q != SA_SWITCH)) |=>
        $stable({vol_l, vol_r, bass, treble, sw}) && $stable(sub_q)); // R9

endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
    import actl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h41,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [VOL_W-1:0]  vol_left,
    output logic [VOL_W-1:0]  vol_right,
    output logic [TONE_W-1:0] bass_code,
    output logic [TONE_W-1:0] treble_code,
    output logic              mute,
    output logic              effect_en,
    output logic              stereo_lin,
    output logic [1:0]        mode_sel,
    output logic              input_sel
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              sub_ld, wr;
    logic [BYTE_W-1:0] byte_q;
    sw_fields_t        sw;

    actl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    actl_rx_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .sub_ld    (sub_ld),
        .wr        (wr),
        .byte_q    (byte_q)
    );

    actl_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_ld  (sub_ld),
        .wr      (wr),
        .byte_in (byte_q),
        .vol_l   (vol_left),
        .vol_r   (vol_right),
        .bass    (bass_code),
        .treble  (treble_code),
        .sw      (sw)
    );

    assign mute       = sw.mute;
    assign effect_en  = sw.effect;
    assign stereo_lin = sw.stereo_lin;
    assign mode_sel   = sw.mode;
    assign input_sel  = sw.input_sel;

endmodule

// File: tb/sim_audio_ctl_rx.sv
module sim_audio_ctl_rx;

    localparam logic [6:0] DEV = 7'h41;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [5:0] vol_left, vol_right;
    logic [3:0] bass_code, treble_code;
    logic mute, effect_en, stereo_lin, input_sel;
    logic [1:0] mode_sel;
    wire sda_bus = sda_m & ~sda_oe;

    audio_ctl_rx #(.DEV_ADDR(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .vol_left(vol_left), .vol_right(vol_right), .bass_code(bass_code),
        .treble_code(treble_code), .mute(mute), .effect_en(effect_en),
        .stereo_lin(stereo_lin), .mode_sel(mode_sel), .input_sel(input_sel)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // reference model
    logic [5:0] m_vl = 0, m_vr = 0, m_sw = 6'b100000;
    logic [3:0] m_ba = 0, m_tr = 0;
    logic [7:0] m_sub = 0;

    function automatic logic [25:0] model_vec();
        return {m_vl, m_vr, m_ba, m_tr, m_sw};
    endfunction

    function automatic logic [25:0] obs_vec();
        return {vol_left, vol_right, bass_code, treble_code,
                mute, effect_en, stereo_lin, mode_sel, input_sel};
    endfunction

    task automatic apply(logic [7:0] d);
        case (m_sub)
            8'h00: m_vl = d[5:0];
            8'h01: m_vr = d[5:0];
            8'h02: m_ba = d[3:0];
            8'h03: m_tr = d[3:0];
            8'h08: m_sw = d[5:0];
            default: ;
        endcase
        if (m_sub <= 8'h02) m_sub = m_sub + 8'h01;
        else if (m_sub == 8'h03) m_sub = 8'h08;
    endtask

    // scoreboard
    typedef struct {
        string      tag;
        bit         is_ack;
        logic [25:0] exp;
    } item_t;
    item_t sbq[$];
    event kick;
    logic got_ack = 0;

    initial begin
        item_t it;
        forever begin
            @(kick);
            @(negedge clk);
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                if (it.is_ack) check(it.tag, "ack", {31'd0, got_ack}, {31'd0, it.exp[0]});
                else           check(it.tag, "regs", {6'd0, obs_vec()}, {6'd0, it.exp});
            end
        end
    end

    // R5 observer: acknowledge drive never moves while SCL is high
    logic prev_oe = 0;
    int   oe_viol = 0;
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) oe_viol++;
        prev_oe <= sda_oe;
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
    endtask

    task automatic clk_bit(logic b);
        sda_m = b; tick(Q); scl_m = 1; tick(2 * Q); scl_m = 0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] b, string tag, logic exp_ack, bit with_regs);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_m = 1; tick(Q); scl_m = 1; tick(Q);
        got_ack = ~sda_bus;
        tick(Q); scl_m = 0; tick(Q);
        check("R5", "sda_oe released after ninth clock", {31'd0, sda_oe}, 32'd0);
        sbq.push_back('{tag, 1'b1, {25'd0, exp_ack}});
        if (with_regs) sbq.push_back('{tag, 1'b0, model_vec()});
        ->kick;
    endtask

    logic [7:0] pay[$];

    task automatic write_seq(string tag, logic [7:0] adr, logic [7:0] sub);
        logic ok;
        ok = (adr == {DEV, 1'b0});
        bus_start();
        send_byte(adr, tag, ok, 0);
        if (ok) m_sub = sub;
        send_byte(sub, tag, ok, 0);
        for (int i = 0; i < pay.size(); i++) begin
            if (ok) apply(pay[i]);
            send_byte(pay[i], tag, ok, 1);
        end
        bus_stop();
        pay.delete();
    endtask

    initial begin
        tick(5);
        rst_n = 1;
        tick(5);
        // R1: power-on state
        check("R1", "regs after reset", {6'd0, obs_vec()}, {6'd0, 26'b100000});
        check("R1", "sda_oe after reset", {31'd0, sda_oe}, 32'd0);

        // R6: single writes, upper bits ignored
        pay = '{8'hFF};       write_seq("R6", 8'h82, 8'h00);
        pay = '{8'h15};       write_seq("R6", 8'h82, 8'h01);

        // R8: full sweep through all five functions
        pay = '{8'hC7, 8'hD9, 8'hF2, 8'hFC, 8'h2A};
        write_seq("R8", 8'h82, 8'h00);

        // R7: switch fields
        pay = '{8'hDB};       write_seq("R7", 8'h82, 8'h08);

        // R8: 03 -> 08 then stays at 08
        pay = '{8'hF5, 8'h04, 8'h3E};
        write_seq("R8", 8'h82, 8'h03);

        // R10: other registers written, mute kept; then switch write clears it
        pay = '{8'hC0, 8'hC1, 8'hF0, 8'hF9};
        write_seq("R10", 8'h82, 8'h00);
        pay = '{8'h00};       write_seq("R10", 8'h82, 8'h08);

        // R9: unmapped subaddresses
        pay = '{8'hFF, 8'hFF}; write_seq("R9", 8'h82, 8'h05);
        pay = '{8'hFF};        write_seq("R9", 8'h82, 8'h09);

        // R4: wrong address and read direction
        pay = '{8'hFF};       write_seq("R4", 8'h84, 8'h00);
        pay = '{8'hFF};       write_seq("R4", 8'h83, 8'h08);

        // R2: START in the middle of a data byte
        bus_start();
        send_byte(8'h82, "R2", 1'b1, 0);
        m_sub = 8'h00;
        send_byte(8'h00, "R2", 1'b1, 0);
        clk_bit(1); clk_bit(0); clk_bit(1); clk_bit(0);
        sbq.push_back('{"R2", 1'b0, model_vec()});
        ->kick;
        pay = '{8'hAB};       write_seq("R2", 8'h82, 8'h01);

        // R2: START in the middle of the address byte
        bus_start();
        clk_bit(1); clk_bit(0); clk_bit(0);
        pay = '{8'hF6};       write_seq("R2", 8'h82, 8'h02);

        // R3: bytes clocked after STOP without a START
        scl_m = 0; tick(Q);
        send_byte(8'h82, "R3", 1'b0, 1);
        send_byte(8'h00, "R3", 1'b0, 1);
        send_byte(8'hC5, "R3", 1'b0, 1);
        bus_stop();

        tick(10);
        check("R5", "sda_oe changes while SCL high", oe_viol, 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all R): actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule